// File: doc/BRIEF.md
# Multichannel ADC Averaging Formatter

This block sits behind a multiplexed analog-to-digital converter that serves up to 64 channels. Raw 14-bit conversion codes arrive one at a time. Each carries a channel number and a valid strobe. For each channel the block sums a configured number of samples and divides the sum by that number. It then packs the truncated mean into a 16-bit result word. The result word uses one of several code layouts, chosen globally and per channel. The result words form a bank with one entry per channel, read through an asynchronous read port.

Configuration is held in a small word-addressed register space, written through a single write port. The address map is:

- Address 0 holds the global resolution word.
- Address 1 holds the code polarity.
- Addresses 4 to 7 hold the per-channel precision bitmap.
- Addresses 32 to 63 hold the per-channel sample counts, two to a word.

Writes that change a channel's averaging or format discard any partial sum that channel holds. A mean is therefore never built from samples taken under two settings.

The raw input is an offset-binary code, 0 to 16383, with mid-scale at 8192. In bipolar mode the block presents the two's-complement equivalent, which is the raw code minus 8192.

Top module: `adc_avg_formatter`

## Requirements
- R1: After exactly N accepted samples on a channel, that channel's result becomes the packed form of floor(sum/N). The result register keeps its previous value while fewer than N samples have been collected.
- R2: The sample count for channel c is a byte in the word at address 32 + c/2. An even channel uses bits 7:0 and an odd channel uses bits 15:8. Legal values are 1 to 16.
- R3: A count byte outside 1 to 16 falls back to a default. The default is 8 when the channel is in full 14-bit precision, and 1 otherwise. Full 14-bit precision requires global 14-bit resolution with the channel's bitmap bit set.
- R4: Writing 16'h5612 to address 0 selects 12-bit resolution for every channel. Writing 16'h5614 selects 14-bit resolution. Any other value written there is ignored.
- R5: In 14-bit resolution, bit c%16 of the bitmap word at address 4 + c/16 selects the precision of channel c: 1 means full 14 bits and 0 means 12 valid bits. In 12-bit resolution the bitmap has no effect on packing.
- R6: Full 14-bit packing. Bipolar results lie in -8192..8191, with bits 15:14 copying bit 13. Unipolar results lie in 0..16383, with bits 15:14 zero.
- R7: 14-bit packing with 12 valid bits gives the same value as R6 with bits 1:0 cleared. Bipolar results lie in -8192..8188 and unipolar results in 0..16380.
- R8: 12-bit packing takes the 14-bit value shifted right arithmetically by two. Bipolar results lie in -2048..2047, with bits 15:12 copying bit 11. Unipolar results lie in 0..4095, with bits 15:12 zero.
- R9: Bit 0 of the word at address 1 selects the code: 1 means bipolar (raw minus 8192) and 0 means unipolar (raw unchanged).
- R10: After reset the block is configured as follows: 14-bit resolution, all channels at 12 valid bits, bipolar code, and every count set to 1. Every result register reads 0.
- R11: A write to a channel's count word or bitmap word clears that channel's partial sum and sample counter. A legal write to address 0, or any write to address 1, clears the partial sum and sample counter of every channel. A sample for a cleared channel arriving in the same cycle as the write is dropped.
- R12: Samples of different channels may interleave freely, and each channel's mean uses only its own samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A raw sample is present this cycle |
| sampleChan | input | 6 | Channel number of the sample |
| sampleData | input | 14 | Offset-binary raw code |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration word address |
| cfgData | input | 16 | Configuration write data |
| rdAddr | input | 6 | Result bank read channel |
| rdData | output | 16 | Packed result of the addressed channel |

## Verification
The bench drives the extremes of each code layout to catch a wrong sign extension or a missing offset flip:

- full-scale and zero-scale codes in bipolar and unipolar form;
- a mean that lands on a non-multiple of four in 12-valid-bit mode, which exposes a missing LSB clear;
- the 12-bit shift, whose absence makes results four times too large.

Illegal count bytes are tested in both precisions. A design with the wrong fallback waits for the wrong number of samples and leaves the old result in place.

A partial sum followed by a rewrite of the count word checks that stale samples are discarded; a design that keeps them reports a mean mixed with the old value. Interleaved traffic on a channel pair checks that accumulators do not leak into each other. A channel read after only N-1 samples checks that no early update occurs.

// File: rtl/adcavg_pkg.sv
package adcavg_pkg;
  localparam int CH_W  = 6;
  localparam int RAW_W = 14;
  localparam int OUT_W = 16;
  localparam int CNT_W = 5;
  localparam int ACC_W = 20;

  localparam logic [15:0] FMT_RES12 = 16'h5612;
  localparam logic [15:0] FMT_RES14 = 16'h5614;

  localparam logic [CH_W-1:0] ADDR_FMT  = 6'd0;
  localparam logic [CH_W-1:0] ADDR_CODE = 6'd1;

  // Clear request from configuration control to the datapath
  typedef struct packed {
    logic       clrAll;
    logic       clrMap;
    logic [1:0] mapIdx;
    logic       clrPair;
    logic [4:0] pairIdx;
  } clrStrobe_t;

  // Pack a 14-bit offset-binary mean into the 16-bit result layouts
  function automatic logic [OUT_W-1:0] packResult(
      input logic [RAW_W-1:0] avg,
      input logic             bip,
      input logic             res14,
      input logic             full14);
    logic [RAW_W-1:0] code;
    logic [11:0]      narrow;
    logic [OUT_W-1:0] word;
    code   = bip ? {~avg[RAW_W-1], avg[RAW_W-2:0]} : avg;
    narrow = code[RAW_W-1:2];
    if (!res14)
      word = bip ? {{4{narrow[11]}}, narrow} : {4'b0, narrow};
    else begin
      word = bip ? {{2{code[RAW_W-1]}}, code} : {2'b0, code};
      if (!full14) word[1:0] = 2'b00;
    end
    return word;
  endfunction
endpackage

// File: rtl/adcavg_div.sv
module adcavg_div #(
  parameter int DVD_W = 20,
  parameter int DVS_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int STEP_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0]  dvdQ, origQ;
  logic [DVS_W-1:0]  dvsQ, remQ;
  logic [STEP_W-1:0] stepQ;
  logic [DVS_W:0]    trial, trialSub;
  logic              fits;

  assign trial    = {remQ, dvdQ[DVD_W-1]};
  assign fits     = trial >= {1'b0, dvsQ};
  assign trialSub = trial - {1'b0, dvsQ};
  assign busy     = stepQ != '0;
  assign quotient = dvdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvdQ  <= '0;
      origQ <= '0;
      dvsQ  <= '0;
      remQ  <= '0;
      stepQ <= '0;
      done  <= 1'b0;
    end else if (start) begin
      dvdQ  <= dividend;
      origQ <= dividend;
      dvsQ  <= divisor;
      remQ  <= '0;
      stepQ <= STEP_W'(DVD_W);
      done  <= 1'b0;
    end else if (busy) begin
      remQ  <= fits ? trialSub[DVS_W-1:0] : trial[DVS_W-1:0];
      dvdQ  <= {dvdQ[DVD_W-2:0], fits};
      stepQ <= stepQ - 1'b1;
      done  <= stepQ == STEP_W'(1);
    end else begin
      done  <= 1'b0;
    end
  end

  logic [DVD_W+DVS_W-1:0] prod;
  assign prod = (DVD_W+DVS_W)'(dvdQ) * (DVD_W+DVS_W)'(dvsQ);

  // R1: quotient and remainder reconstruct the dividend exactly
  a_r1_div_exact: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (prod + (DVD_W+DVS_W)'(remQ) == (DVD_W+DVS_W)'(origQ)));
  a_r1_div_remainder: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remQ < dvsQ));
endmodule

// File: rtl/adcavg_ctrl.sv
module adcavg_ctrl
  import adcavg_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWrEn,
  input  logic [CH_W-1:0]                cfgAddr,
  input  logic [15:0]                    cfgData,
  output clrStrobe_t                     clrStb,
  output logic                           res14,
  output logic                           bipolar,
  output logic [NUM_CH-1:0][CNT_W-1:0]   effCnt,
  output logic [NUM_CH-1:0]              chFull14
);
  localparam int MAP_BITS = 16;

  logic [NUM_CH-1:0]      mapQ;
  logic [NUM_CH-1:0][7:0] cntByteQ;
  logic isFmt, isCode, isMap, isCnt, fmtLegal;

  assign fmtLegal = (cfgData == FMT_RES12) || (cfgData == FMT_RES14);
  assign isFmt    = cfgWrEn && (cfgAddr == ADDR_FMT);
  assign isCode   = cfgWrEn && (cfgAddr == ADDR_CODE);
  assign isMap    = cfgWrEn && (cfgAddr[CH_W-1:2] == 4'd1);
  assign isCnt    = cfgWrEn && cfgAddr[CH_W-1];

  always_comb begin
    clrStb         = '0;
    clrStb.clrAll  = (isFmt && fmtLegal) || isCode;
    clrStb.clrMap  = isMap;
    clrStb.mapIdx  = cfgAddr[1:0];
    clrStb.clrPair = isCnt;
    clrStb.pairIdx = cfgAddr[4:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      res14   <= 1'b1;
      bipolar <= 1'b1;
      mapQ    <= '0;
      for (int ch = 0; ch < NUM_CH; ch++) cntByteQ[ch] <= 8'd1;
    end else begin
      if (isFmt && fmtLegal) res14 <= (cfgData == FMT_RES14);
      if (isCode) bipolar <= cfgData[0];
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (isMap && (ch / MAP_BITS) == int'(cfgAddr[1:0]))
          mapQ[ch] <= cfgData[ch % MAP_BITS];
        if (isCnt && (ch / 2) == int'(cfgAddr[4:0]))
          cntByteQ[ch] <= (ch % 2 == 1) ? cfgData[15:8] : cfgData[7:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_eff
    logic legal;
    assign legal       = (cntByteQ[g] >= 8'd1) && (cntByteQ[g] <= 8'd16);
    assign chFull14[g] = res14 && mapQ[g];
    assign effCnt[g]   = legal ? cntByteQ[g][CNT_W-1:0]
                               : (chFull14[g] ? CNT_W'(8) : CNT_W'(1));
  end

  // R4: an unrecognised resolution word leaves the resolution unchanged
  a_r4_bad_format_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (isFmt && !fmtLegal) |=> $stable(res14));
  // R3: the count handed to the datapath is always within 1..16
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (effCnt[0] != '0) && (effCnt[0] <= CNT_W'(16)));
endmodule

// File: rtl/adcavg_datapath.sv
module adcavg_datapath
  import adcavg_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleValid,
  input  logic [CH_W-1:0]              sampleChan,
  input  logic [RAW_W-1:0]             sampleData,
  input  clrStrobe_t                   clrStb,
  input  logic                         res14,
  input  logic                         bipolar,
  input  logic [NUM_CH-1:0][CNT_W-1:0] effCnt,
  input  logic [NUM_CH-1:0]            chFull14,
  input  logic [CH_W-1:0]              rdAddr,
  output logic [OUT_W-1:0]             rdData
);
  logic [NUM_CH-1:0][ACC_W-1:0] accQ;
  logic [NUM_CH-1:0][CNT_W-1:0] cntQ;
  logic [NUM_CH-1:0][OUT_W-1:0] resultQ;
  logic [NUM_CH-1:0]            chClr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_clr
    assign chClr[g] = clrStb.clrAll
                   || (clrStb.clrMap  && (g / 16) == int'(clrStb.mapIdx))
                   || (clrStb.clrPair && (g / 2)  == int'(clrStb.pairIdx));
  end

  logic             hit, complete;
  logic [ACC_W-1:0] sumNext;
  logic [CNT_W-1:0] cntNext;

  assign hit      = sampleValid && (int'(sampleChan) < NUM_CH) && !chClr[sampleChan];
  assign sumNext  = accQ[sampleChan] + ACC_W'(sampleData);
  assign cntNext  = cntQ[sampleChan] + 1'b1;
  assign complete = hit && (cntNext == effCnt[sampleChan]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      cntQ <= '0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++)
        if (chClr[ch]) begin
          accQ[ch] <= '0;
          cntQ[ch] <= '0;
        end
      if (hit) begin
        accQ[sampleChan] <= complete ? '0 : sumNext;
        cntQ[sampleChan] <= complete ? '0 : cntNext;
      end
    end
  end

  logic             divBusy, divDone;
  logic [ACC_W-1:0] divQuot;
  logic             jobValid;
  logic [CH_W-1:0]  jobChan;

  adcavg_div #(.DVD_W(ACC_W), .DVS_W(CNT_W)) i_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (complete),
    .dividend (sumNext),
    .divisor  (effCnt[sampleChan]),
    .busy     (divBusy),
    .done     (divDone),
    .quotient (divQuot)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      jobValid <= 1'b0;
      jobChan  <= '0;
    end else if (complete) begin
      jobValid <= 1'b1;
      jobChan  <= sampleChan;
    end else if (jobValid && (chClr[jobChan] || divDone)) begin
      jobValid <= 1'b0;
    end
  end

  logic writeBack;
  assign writeBack = divDone && jobValid && !chClr[jobChan];

  always_ff @(posedge clk) begin
    if (!rstN) resultQ <= '0;
    else if (writeBack)
      resultQ[jobChan] <= packResult(divQuot[RAW_W-1:0], bipolar, res14, chFull14[jobChan]);
  end

  assign rdData = (int'(rdAddr) < NUM_CH) ? resultQ[rdAddr] : '0;

  // R1: a new average may only start once the divider is idle
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    complete |-> !divBusy);
  // R1: a mean of 14-bit samples never exceeds 14 bits
  a_r1_mean_fits: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> (divQuot[ACC_W-1:RAW_W] == '0));
  // R11: a global clear empties the partial sums
  a_r11_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    clrStb.clrAll |=> (cntQ[0] == '0) && (accQ[0] == '0));
  // R7: 12-valid-bit results in 14-bit mode have zero LSBs
  a_r7_lsbs_zero: assert property (@(posedge clk) disable iff (!rstN)
    (writeBack && res14 && !chFull14[jobChan]) |=> (resultQ[$past(jobChan)][1:0] == 2'b00));
endmodule

// File: rtl/adc_avg_formatter.sv
module adc_avg_formatter
  import adcavg_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [5:0]       sampleChan,
  input  logic [13:0]      sampleData,
  input  logic             cfgWrEn,
  input  logic [5:0]       cfgAddr,
  input  logic [15:0]      cfgData,
  input  logic [5:0]       rdAddr,
  output logic [15:0]      rdData
);
  clrStrobe_t                   clrStb;
  logic                         res14, bipolar;
  logic [NUM_CH-1:0][CNT_W-1:0] effCnt;
  logic [NUM_CH-1:0]            chFull14;

  adcavg_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .clrStb   (clrStb),
    .res14    (res14),
    .bipolar  (bipolar),
    .effCnt   (effCnt),
    .chFull14 (chFull14)
  );

  adcavg_datapath #(.NUM_CH(NUM_CH)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleChan  (sampleChan),
    .sampleData  (sampleData),
    .clrStb      (clrStb),
    .res14       (res14),
    .bipolar     (bipolar),
    .effCnt      (effCnt),
    .chFull14    (chFull14),
    .rdAddr      (rdAddr),
    .rdData      (rdData)
  );
endmodule

// File: tb/test_adc_avg_formatter.sv
module test_adc_avg_formatter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [5:0]  sampleChan = '0;
  logic [13:0] sampleData = '0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic [5:0]  rdAddr = '0;
  logic [15:0] rdData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_avg_formatter i_adc_avg_formatter (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleData(sampleData), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .rdAddr(rdAddr), .rdData(rdData));

  typedef struct packed {
    bit          res14;
    bit          bip;
    bit          full;
    logic [7:0]  cnt;
    logic [5:0]  ch;
    logic [13:0] a;
    logic [13:0] b;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b1, 8'd4,   6'd0,  14'd16383, 14'd16383},
    '{1'b1, 1'b0, 1'b1, 8'd3,   6'd7,  14'd100,   14'd101},
    '{1'b1, 1'b1, 1'b0, 8'd2,   6'd13, 14'd8193,  14'd8200},
    '{1'b0, 1'b1, 1'b1, 8'd1,   6'd20, 14'd0,     14'd0},
    '{1'b0, 1'b0, 1'b0, 8'd5,   6'd33, 14'd4000,  14'd4003},
    '{1'b1, 1'b1, 1'b1, 8'd0,   6'd40, 14'd8292,  14'd8142},
    '{1'b1, 1'b1, 1'b0, 8'd200, 6'd41, 14'd9001,  14'd0},
    '{1'b0, 1'b1, 1'b1, 8'd17,  6'd63, 14'd16383, 14'd0},
    '{1'b1, 1'b0, 1'b1, 8'd16,  6'd62, 14'd16383, 14'd16383},
    '{1'b1, 1'b1, 1'b0, 8'd1,   6'd5,  14'd0,     14'd0}
  };

  function automatic logic [15:0] model(int avg, bit bip, bit res14, bit full);
    int s;
    s = bip ? avg - 8192 : avg;
    if (!res14) s = s >>> 2;
    else if (!full) s = s & ~3;
    return s[15:0];
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cfgWrite(logic [5:0] addr, logic [15:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = addr; cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendSample(logic [5:0] ch, logic [13:0] val);
    @(negedge clk);
    sampleValid = 1'b1; sampleChan = ch; sampleData = val;
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic readCh(logic [5:0] ch, output logic [15:0] val);
    @(negedge clk);
    rdAddr = ch;
    #1 val = rdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R10: result bank cleared at reset
    readCh(6'd0, v);  check("R10 reset ch0", v, 16'h0);
    readCh(6'd63, v); check("R10 reset ch63", v, 16'h0);
    // R10: default count 1, bipolar, 14-bit with 12 valid bits
    sendSample(6'd2, 14'd8200);
    readCh(6'd2, v); check("R10 R9 defaults", v, model(8200, 1, 1, 0));
    // R4: illegal resolution word ignored, 14-bit stays
    cfgWrite(6'd0, 16'h1234);
    sendSample(6'd3, 14'd8205);
    readCh(6'd3, v); check("R4 illegal format", v, model(8205, 1, 1, 0));

    // Table walk: R2 R3 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      vec_t e;
      int n, sum;
      string tag;
      e = VECS[i];
      cfgWrite(6'd0, e.res14 ? 16'h5614 : 16'h5612);
      cfgWrite(6'd1, {15'd0, e.bip});
      cfgWrite(6'd4 + 6'(e.ch / 16), 16'(e.full) << (e.ch % 16));
      cfgWrite(6'd32 + 6'(e.ch / 2), e.ch[0] ? {e.cnt, 8'd1} : {8'd1, e.cnt});
      n = (e.cnt >= 1 && e.cnt <= 16) ? int'(e.cnt) : ((e.res14 && e.full) ? 8 : 1);
      sum = 0;
      for (int k = 0; k < n; k++) begin
        sendSample(e.ch, k == 0 ? e.a : e.b);
        sum += (k == 0) ? int'(e.a) : int'(e.b);
      end
      readCh(e.ch, v);
      tag = !e.res14 ? "R8" : (e.full ? "R6 R5" : "R7 R5");
      tag = {tag, e.bip ? " R9 bip" : " R9 unip", " R2"};
      if (e.cnt < 1 || e.cnt > 16) tag = {tag, " R3"};
      check(tag, v, model(sum / n, e.bip, e.res14, e.full));
    end

    // Back to 14-bit, bipolar, 12 valid bits for the directed tests
    cfgWrite(6'd0, 16'h5614);
    cfgWrite(6'd1, 16'd1);
    cfgWrite(6'd4, 16'd0);

    // R1: no update before the N-th sample (ch10 count 3, ch11 count 2)
    cfgWrite(6'd37, {8'd2, 8'd3});
    sendSample(6'd10, 14'd9000);
    sendSample(6'd10, 14'd9000);
    readCh(6'd10, v); check("R1 partial hold", v, 16'h0);
    sendSample(6'd10, 14'd9003);
    readCh(6'd10, v); check("R1 block mean", v, model(27003 / 3, 1, 1, 0));

    // R11: rewriting the count word discards the partial sum
    sendSample(6'd11, 14'd1000);
    cfgWrite(6'd37, {8'd2, 8'd3});
    sendSample(6'd11, 14'd3000);
    readCh(6'd11, v); check("R11 cleared no early update", v, 16'h0);
    sendSample(6'd11, 14'd3000);
    readCh(6'd11, v); check("R11 clear on rewrite", v, model(3000, 1, 1, 0));

    // R12: interleaved channels stay independent
    cfgWrite(6'd44, {8'd2, 8'd2});
    sendSample(6'd24, 14'd9000);
    sendSample(6'd25, 14'd7000);
    sendSample(6'd24, 14'd9004);
    sendSample(6'd25, 14'd7008);
    readCh(6'd24, v); check("R12 ch24", v, model(9002, 1, 1, 0));
    readCh(6'd25, v); check("R12 ch25", v, model(7004, 1, 1, 0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule